// File: doc/BRIEF.md
# Persistent Memory Window Controller

This block decodes a programmable address window over a persistent memory region whose size is a power of two. Software programs it through a small 32-bit register interface. One control register switches the region on and off, and one status register reports not-ready and an invalid base. A 64-bit memory space control value is written as two 32-bit halves and carries the window enable bit and the base address.

The window is armed only at the moment the low half is written. At that point the block computes the 4 KiB-aligned base from the full 64-bit value and checks whether base plus region size carries past 2^64. If it does, the block refuses to arm and raises a sticky flag. If it does not, the block latches the base and opens the window.

A separate combinational lookup port takes an address and a length. It reports whether the address lies inside the open window. It also reports whether a transfer fits, which requires both its first and its last byte to be inside the window.

Top module: `pmw_ctrl`

## Requirements
- R1: After reset the window is closed. The status register (0xE08) reads 0x1, bit 0 being not-ready. The control register (0xE04) and both memory space control halves (0xE14, 0xE18) read 0.
- R2: The capability register at 0xE00 reads 0x7. Bit 0 means read-data support, bit 1 write-data support and bit 2 memory space control support. Any unmapped offset reads 0.
- R3: A write to 0xE18 replaces bits 63:32 of the memory space control value. It leaves the window enable and the latched base unchanged.
- R4: A write to 0xE14 replaces bits 31:0 and closes the window. If bit 1 of the written value is set and no wrap occurs, the window opens with base = {bits 63:12, 12'b0}.
- R5: If base + 2^SIZE_LOG2 carries past 2^64 on a 0xE14 arming write, status bit 1 (base invalid) is set and the window stays closed. The bit stays set across later successful arming.
- R6: Writes to 0xE14 and 0xE18 have no effect while cap_present is low.
- R7: A control write with bit 0 clear closes the window and sets status bit 0. A control write with bit 0 set clears the whole status register to 0.
- R8: chk_hit is 1 only when the window is open and base <= chk_addr < base + 2^SIZE_LOG2.
- R9: For chk_len > 0, chk_ok is 1 only if both chk_addr and chk_addr+chk_len-1 are inside the window. chk_err is always the inverse of chk_ok.
- R10: A zero-length transfer always gives chk_ok = 1.
- R11: Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_present | input | 1 | Persistent memory capability present |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| chk_addr | input | 64 | Lookup address |
| chk_len | input | 32 | Lookup transfer length in bytes |
| chk_hit | output | 1 | chk_addr is inside the open window |
| chk_ok | output | 1 | Transfer fits entirely in the window |
| chk_err | output | 1 | Transfer error |

## Verification
The hardest case to reach is the wrap refusal. It needs the high half loaded near the top of the address space before the low half arms. The stimulus writes 0xFFFFFFFF to the high half and then arms with a base that makes the sum land exactly on 2^64. A base one region lower is then armed to show the flag stays sticky while the window still opens. Transfers that straddle the top end, the bottom end and the 64-bit address ceiling exercise the last-byte check.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam logic [11:0] OFF_CAP    = 12'hE00;
  localparam logic [11:0] OFF_CTRL   = 12'hE04;
  localparam logic [11:0] OFF_STS    = 12'hE08;
  localparam logic [11:0] OFF_MSC_LO = 12'hE14;
  localparam logic [11:0] OFF_MSC_HI = 12'hE18;
  localparam logic [31:0] CAP_VALUE  = 32'h0000_0007;
  localparam int          MSC_EN_BIT = 1;

  // Clear the low address bits below the alignment shift.
  function automatic logic [63:0] base_of(input logic [63:0] msc, input int unsigned shift);
    return msc & ~((64'd1 << shift) - 64'd1);
  endfunction

  // One past the last byte, kept in 65 bits so a wrap is visible.
  function automatic logic [64:0] limit_of(input logic [63:0] base, input int unsigned size_log2);
    return {1'b0, base} + (65'd1 << size_log2);
  endfunction

  function automatic logic wraps(input logic [63:0] base, input int unsigned size_log2);
    logic [64:0] lim;
    lim = limit_of(base, size_log2);
    return lim[64];
  endfunction

  function automatic logic in_window(input logic en, input logic [63:0] base,
                                     input int unsigned size_log2, input logic [64:0] a);
    return en && (a >= {1'b0, base}) && (a < limit_of(base, size_log2));
  endfunction
endpackage

// File: rtl/pmw_regs.sv
module pmw_regs
  import pmw_pkg::*;
#(
  parameter int unsigned SIZE_LOG2  = 20,
  parameter int unsigned BASE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_present,
  input  logic        wr_en,
  input  logic [11:0] addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        win_en,
  output logic [63:0] win_base,
  output logic [63:0] msc_val,
  output logic        sts_nrdy,
  output logic        sts_binv,
  output logic        ev_hi_wr,
  output logic        ev_wrap
);
  logic [31:0] ctrl_q;
  logic [63:0] msc_q;
  logic [63:0] base_q;
  logic        en_q, nrdy_q, binv_q;

  logic        wr_ctrl, wr_lo, wr_hi, arm_req, arm_ok;
  logic [63:0] msc_cand, base_cand;

  assign wr_ctrl   = wr_en && (addr == OFF_CTRL);
  assign wr_lo     = wr_en && (addr == OFF_MSC_LO) && cap_present;
  assign wr_hi     = wr_en && (addr == OFF_MSC_HI) && cap_present;
  assign msc_cand  = {msc_q[63:32], wr_data};
  assign base_cand = base_of(msc_cand, BASE_SHIFT);
  assign arm_req   = wr_lo && wr_data[MSC_EN_BIT];
  assign ev_wrap   = arm_req && wraps(base_cand, SIZE_LOG2);
  assign arm_ok    = arm_req && !wraps(base_cand, SIZE_LOG2);
  assign ev_hi_wr  = wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      msc_q  <= '0;
      base_q <= '0;
      en_q   <= 1'b0;
      nrdy_q <= 1'b1;
      binv_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= wr_data;
        if (wr_data[0]) begin
          nrdy_q <= 1'b0;
          binv_q <= 1'b0;
        end else begin
          nrdy_q <= 1'b1;
          en_q   <= 1'b0;
        end
      end
      if (wr_lo) begin
        msc_q[31:0] <= wr_data;
        en_q        <= arm_ok;
        if (arm_ok)  base_q <= base_cand;
        if (ev_wrap) binv_q <= 1'b1;
      end
      if (wr_hi) msc_q[63:32] <= wr_data;
    end
  end

  always_comb begin
    case (addr)
      OFF_CAP:    rd_data = CAP_VALUE;
      OFF_CTRL:   rd_data = ctrl_q;
      OFF_STS:    rd_data = {30'd0, binv_q, nrdy_q};
      OFF_MSC_LO: rd_data = msc_q[31:0];
      OFF_MSC_HI: rd_data = msc_q[63:32];
      default:    rd_data = 32'd0;
    endcase
  end

  assign win_en   = en_q;
  assign win_base = base_q;
  assign msc_val  = msc_q;
  assign sts_nrdy = nrdy_q;
  assign sts_binv = binv_q;
endmodule

// File: rtl/pmw_hit.sv
module pmw_hit
  import pmw_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 20
) (
  input  logic        en,
  input  logic [63:0] base,
  input  logic [64:0] probe,
  output logic        hit
);
  assign hit = in_window(en, base, SIZE_LOG2, probe);
endmodule

// File: rtl/pmw_ctrl.sv
module pmw_ctrl
  import pmw_pkg::*;
#(
  parameter int unsigned SIZE_LOG2  = 20,
  parameter int unsigned BASE_SHIFT = 12,
  parameter int unsigned LEN_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_present,
  input  logic             reg_wr,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [63:0]      chk_addr,
  input  logic [LEN_W-1:0] chk_len,
  output logic             chk_hit,
  output logic             chk_ok,
  output logic             chk_err
);
  localparam int unsigned NPROBE = 2;

  logic        win_en, sts_nrdy, sts_binv, ev_hi_wr, ev_wrap;
  logic [63:0] win_base, msc_val;
  logic [64:0] probe [NPROBE];
  logic [NPROBE-1:0] probe_hit;

  pmw_regs #(.SIZE_LOG2(SIZE_LOG2), .BASE_SHIFT(BASE_SHIFT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_present(cap_present),
    .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata), .rd_data(reg_rdata),
    .win_en(win_en), .win_base(win_base), .msc_val(msc_val),
    .sts_nrdy(sts_nrdy), .sts_binv(sts_binv),
    .ev_hi_wr(ev_hi_wr), .ev_wrap(ev_wrap)
  );

  // probe 0: first byte, probe 1: last byte (65 bits so the end cannot alias)
  assign probe[0] = {1'b0, chk_addr};
  assign probe[1] = {1'b0, chk_addr} + {{(65-LEN_W){1'b0}}, chk_len} - 65'd1;

  for (genvar g = 0; g < NPROBE; g++) begin : g_probe
    pmw_hit #(.SIZE_LOG2(SIZE_LOG2)) u_hit (
      .en(win_en), .base(win_base), .probe(probe[g]), .hit(probe_hit[g])
    );
  end

  assign chk_hit = probe_hit[0];
  assign chk_ok  = (chk_len == '0) || (&probe_hit);
  assign chk_err = !chk_ok;
endmodule

// File: rtl/pmw_ctrl_chk.sv
module pmw_ctrl_chk
  import pmw_pkg::*;
#(
  parameter int unsigned LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_present,
  input logic             reg_wr,
  input logic [11:0]      reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [LEN_W-1:0] chk_len,
  input logic             chk_hit,
  input logic             chk_ok,
  input logic             win_en,
  input logic [63:0]      msc_val,
  input logic             sts_nrdy,
  input logic             sts_binv,
  input logic             ev_hi_wr,
  input logic             ev_wrap
);
  p_hi_keeps_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hi_wr |=> win_en == $past(win_en));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> (!win_en && sts_binv));

  p_nocap_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !cap_present && (reg_addr == OFF_MSC_LO || reg_addr == OFF_MSC_HI))
      |=> $stable(msc_val));

  p_ctrl_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CTRL && !reg_wdata[0]) |=> (!win_en && sts_nrdy));

  p_hit_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hit |-> win_en);

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_len == '0) |-> chk_ok);

  p_sts_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_STS) |=> ($stable(sts_nrdy) && $stable(sts_binv)));
endmodule

bind pmw_ctrl pmw_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_present(cap_present), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .chk_len(chk_len),
  .chk_hit(chk_hit), .chk_ok(chk_ok), .win_en(win_en), .msc_val(msc_val),
  .sts_nrdy(sts_nrdy), .sts_binv(sts_binv), .ev_hi_wr(ev_hi_wr), .ev_wrap(ev_wrap)
);

// File: tb/pmw_ctrl_tb.sv
module pmw_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_present = 1'b1;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = 12'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [63:0] chk_addr = 64'h0;
  logic [31:0] chk_len = 32'h0;
  logic        chk_hit, chk_ok, chk_err;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pmw_ctrl u_dut (.*);

  // {addr, len, expected hit, expected ok} for window [0x1_0040_0000, 0x1_0050_0000)
  localparam logic [97:0] VEC [10] = '{
    {64'h0000_0001_0040_0000, 32'd1,        1'b1, 1'b1},
    {64'h0000_0001_004F_FFFF, 32'd1,        1'b1, 1'b1},
    {64'h0000_0001_0050_0000, 32'd1,        1'b0, 1'b0},
    {64'h0000_0001_003F_FFFF, 32'd4,        1'b0, 1'b0},
    {64'h0000_0001_004F_FFF0, 32'd16,       1'b1, 1'b1},
    {64'h0000_0001_004F_FFF0, 32'd17,       1'b1, 1'b0},
    {64'h0000_0001_0040_0000, 32'h10_0000,  1'b1, 1'b1},
    {64'h0000_0000_0000_0000, 32'd0,        1'b0, 1'b1},
    {64'h0000_0001_003F_FFFF, 32'd0,        1'b0, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 32'd2,        1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic look(input string req, input logic [63:0] a, input logic [31:0] l,
                      input logic eh, input logic eo);
    chk_addr = a; chk_len = l;
    #1;
    check({req, " hit"}, {63'd0, chk_hit}, {63'd0, eh});
    check({req, " ok"},  {63'd0, chk_ok},  {63'd0, eo});
    check({req, " err"}, {63'd0, chk_err}, {63'd0, !eo});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 status", 12'hE08, 32'h1);
    rd("R1 ctrl",   12'hE04, 32'h0);
    rd("R1 msc lo", 12'hE14, 32'h0);
    rd("R1 msc hi", 12'hE18, 32'h0);
    look("R1 closed", 64'h0, 32'd1, 1'b0, 1'b0);
    // R2 capability and unmapped
    rd("R2 cap", 12'hE00, 32'h7);
    rd("R2 unmapped", 12'hE0C, 32'h0);
    // R7 enable clears status
    wr(12'hE04, 32'h1);
    rd("R7 status cleared", 12'hE08, 32'h0);
    // R4 arm with enable clear: stays closed
    wr(12'hE18, 32'h1);
    wr(12'hE14, 32'h0040_0000);
    look("R4 no enable bit", 64'h1_0040_0000, 32'd1, 1'b0, 1'b0);
    // R4 arm
    wr(12'hE14, 32'h0040_0ABE);
    rd("R4 lo readback", 12'hE14, 32'h0040_0ABE);
    // R8 R9 R10 table
    for (int i = 0; i < 10; i++)
      look($sformatf("R8/R9/R10 vec%0d", i), VEC[i][97:34], VEC[i][33:2], VEC[i][1], VEC[i][0]);
    // R3 high write keeps window and base
    wr(12'hE18, 32'h5);
    rd("R3 hi readback", 12'hE18, 32'h5);
    look("R3 window kept", 64'h1_0040_0000, 32'd1, 1'b1, 1'b1);
    // R6 no capability
    cap_present = 1'b0;
    wr(12'hE14, 32'h0);
    wr(12'hE18, 32'h9);
    rd("R6 lo kept", 12'hE14, 32'h0040_0ABE);
    rd("R6 hi kept", 12'hE18, 32'h5);
    look("R6 window kept", 64'h1_0040_0000, 32'd1, 1'b1, 1'b1);
    cap_present = 1'b1;
    // R11 status write ignored
    wr(12'hE08, 32'hFFFF_FFFF);
    rd("R11 status", 12'hE08, 32'h0);
    // R5 wrap: base 0xFFFF_FFFF_FFF0_0000 + 1 MiB = 2^64
    wr(12'hE18, 32'hFFFF_FFFF);
    wr(12'hE14, 32'hFFF0_0002);
    rd("R5 invalid set", 12'hE08, 32'h2);
    look("R5 closed", 64'hFFFF_FFFF_FFF0_0000, 32'd1, 1'b0, 1'b0);
    look("R5 old base closed", 64'h1_0040_0000, 32'd1, 1'b0, 1'b0);
    wr(12'hE14, 32'hFFE0_0002);
    rd("R5 sticky", 12'hE08, 32'h2);
    look("R5 top window", 64'hFFFF_FFFF_FFEF_FFFF, 32'd1, 1'b1, 1'b1);
    look("R9 past top", 64'hFFFF_FFFF_FFEF_FFFF, 32'd2, 1'b1, 1'b0);
    wr(12'hE04, 32'h1);
    rd("R7 clears invalid", 12'hE08, 32'h0);
    // R7 disable
    wr(12'hE04, 32'h0);
    rd("R7 not ready", 12'hE08, 32'h1);
    rd("R7 ctrl readback", 12'hE04, 32'h0);
    look("R7 closed", 64'hFFFF_FFFF_FFE0_0000, 32'd1, 1'b0, 1'b0);
    look("R10 zero len closed", 64'hFFFF_FFFF_FFE0_0000, 32'd0, 1'b0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule